// File: doc/BRIEF.md
# SECDED-protected dual-clock memory

This block is a simple dual-port memory of 512 words. Each word holds 64 data bits and 8 check bits. The write port and the read port each have their own clock, address and enable. On a write, an extended Hamming encoder computes the check bits and stores them beside the data. The encoder result for the current write data is always visible on a dedicated bus.

On a read, a decoder checks the stored word. It corrects a single flipped bit on the way out and flags a double flip that it cannot correct. The corrected value reaches only the output; the stored word keeps its fault. Two further modes let a user bypass part of the code. In decode-only mode the stored check bits come from an external input, which also allows deliberate fault injection. In encode-only mode a read returns the raw stored data and check bits without decoding.

Top module: `eccDualMem`

## Requirements
- R1: While `rstN` is low, `rdData`, `rdChk`, `sglErr` and `dblErr` are all zero.
- R2: A word is stored on a rising `wrClk` edge only when `wrEn` is 1; with `wrEn` at 0 the addressed word keeps its old content.
- R3: On a rising `rdClk` edge with `rdEn` at 1, all four read outputs take the result for the word at `rdAddr`, valid right after that edge. With `rdEn` at 0 they hold their values.
- R4: `encChk` is a combinational function of `wrData`. Number the code positions 1 to 71 and give the 64 positions that are not powers of two to data bits 0..63 in ascending order. Then `encChk[k]` for k in 0..6 is the XOR of the data bits whose position has bit k set, and `encChk[7]` is the XOR of all 64 data bits and `encChk[6:0]`.
- R5: Mode is `mode[1:0]`: 0 normal, 1 encode-only, 2 decode-only, 3 behaves as normal. In modes 0, 2 and 3, a write stores `encChk` with the data, except mode 2 as given in R10. Reading back a clean word gives the written data with both flags at 0.
- R6: When one data bit of a stored word is flipped, a decoding read returns the original data with `sglErr` at 1 and `dblErr` at 0.
- R7: When exactly one check bit, including bit 7, is flipped, a decoding read returns the stored data unchanged with `sglErr` at 1 and `dblErr` at 0.
- R8: When two bits are flipped, a decoding read sets `dblErr` to 1 and `sglErr` to 0 and returns the stored data uncorrected. Both flags are never 1 together.
- R9: Correction is never written back: reading a faulty word again gives the same flags again.
- R10: In mode 2 the check bits stored by a write are `wrChk` instead of `encChk`.
- R11: A read in mode 1 returns the raw stored data on `rdData` and the stored check bits on `rdChk`, with both flags at 0. A read in any other mode drives `rdChk` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Active-low asynchronous clear of the read outputs |
| wrClk | input | 1 | Write port clock |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 9 | Write address |
| wrData | input | 64 | Write data |
| wrChk | input | 8 | External check bits, stored in decode-only mode |
| mode | input | 2 | 0 normal, 1 encode-only, 2 decode-only, 3 normal |
| rdClk | input | 1 | Read port clock |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 9 | Read address |
| rdData | output | 64 | Read data, corrected unless encode-only |
| rdChk | output | 8 | Stored check bits in encode-only mode, else zero |
| sglErr | output | 1 | Single-bit error seen (and corrected if in data) |
| dblErr | output | 1 | Uncorrectable double-bit error seen |
| encChk | output | 8 | Encoder result for the current `wrData` |

## Verification
A write on one port and a decoding read on the other can fall on the same clock edge. While the write changes `encChk` and fills one word, the read must decode a different word. The bench runs both clocks in phase and forks a write task and a read task to different addresses, so both edges coincide. A behavioural model then checks the read result, the flags and the encoder bus together in that cycle. The model uses an independent position-XOR formulation of the code.

// File: rtl/eccPkg.sv
package eccPkg;
  localparam int DataW = 64;
  localparam int HamW  = 7;
  localparam int ChkW  = HamW + 1;
  localparam int CodeN = DataW + HamW;

  typedef enum logic [1:0] {
    ModeNormal  = 2'd0,
    ModeEncOnly = 2'd1,
    ModeDecOnly = 2'd2,
    ModeSpare   = 2'd3
  } modeT;

  typedef struct packed {
    logic write;
    logic extChk;
  } wrStrobeT;

  typedef struct packed {
    logic read;
    logic bypass;
  } rdStrobeT;

  // Code position of data bit idx: non-power-of-two slots, ascending.
  function automatic logic [HamW-1:0] posOfBit(int idx);
    int cnt;
    logic [HamW-1:0] res;
    cnt = 0;
    res = '0;
    for (int p = 1; p <= CodeN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p[HamW-1:0];
        cnt++;
      end
    end
    return res;
  endfunction

  // Data bits covered by Hamming check bit k.
  function automatic logic [DataW-1:0] coverMask(int k);
    logic [DataW-1:0] m;
    logic [HamW-1:0] pos;
    m = '0;
    for (int i = 0; i < DataW; i++) begin
      pos  = posOfBit(i);
      m[i] = pos[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/eccEncoder.sv
module eccEncoder
  import eccPkg::*;
(
  input  logic [DataW-1:0] data,
  output logic [ChkW-1:0]  chk
);
  logic [HamW-1:0] ham;

  for (genvar k = 0; k < HamW; k++) begin : gHam
    localparam logic [DataW-1:0] Cover = coverMask(k);
    assign ham[k] = ^(data & Cover);
  end

  assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/eccDecoder.sv
module eccDecoder
  import eccPkg::*;
(
  input  logic [DataW-1:0] rawData,
  input  logic [ChkW-1:0]  rawChk,
  output logic [DataW-1:0] fixData,
  output logic             single,
  output logic             double
);
  logic [HamW-1:0]  syn;
  logic [DataW-1:0] flip;
  logic             oddParity;

  for (genvar k = 0; k < HamW; k++) begin : gSyn
    localparam logic [DataW-1:0] Cover = coverMask(k);
    assign syn[k] = (^(rawData & Cover)) ^ rawChk[k];
  end

  assign oddParity = ^{rawChk, rawData};

  for (genvar i = 0; i < DataW; i++) begin : gFlip
    localparam logic [HamW-1:0] BitPos = posOfBit(i);
    assign flip[i] = oddParity && (syn == BitPos);
  end

  assign fixData = rawData ^ flip;
  assign single  = oddParity;
  assign double  = !oddParity && (syn != '0);
endmodule

// File: rtl/eccCtrl.sv
module eccCtrl
  import eccPkg::*;
(
  input  logic [1:0] mode,
  input  logic       wrEn,
  input  logic       rdEn,
  output wrStrobeT   wrS,
  output rdStrobeT   rdS
);
  modeT curMode;
  assign curMode = modeT'(mode);

  always_comb begin
    wrS.write  = wrEn;
    wrS.extChk = (curMode == ModeDecOnly);
    rdS.read   = rdEn;
    rdS.bypass = (curMode == ModeEncOnly);
  end
endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccPkg::*;
#(
  parameter int AddrW = 9
) (
  input  logic             rstN,
  input  logic             wrClk,
  input  wrStrobeT         wrS,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [ChkW-1:0]  wrChk,
  input  logic             rdClk,
  input  rdStrobeT         rdS,
  input  logic [AddrW-1:0] rdAddr,
  output logic [DataW-1:0] rdData,
  output logic [ChkW-1:0]  rdChk,
  output logic             sglErr,
  output logic             dblErr,
  output logic [ChkW-1:0]  encChk
);
  localparam int Depth = 1 << AddrW;
  localparam int WordW = DataW + ChkW;

  logic [WordW-1:0] mem [Depth];
  logic [ChkW-1:0]  storeChk;
  logic [WordW-1:0] rdWord;
  logic [DataW-1:0] fixData;
  logic             single;
  logic             double;

  eccEncoder wrEnc (
    .data(wrData),
    .chk (encChk)
  );

  assign storeChk = wrS.extChk ? wrChk : encChk;

  always_ff @(posedge wrClk) begin
    if (wrS.write) mem[wrAddr] <= {storeChk, wrData};
  end

  assign rdWord = mem[rdAddr];

  eccDecoder rdDec (
    .rawData(rdWord[DataW-1:0]),
    .rawChk (rdWord[WordW-1:DataW]),
    .fixData(fixData),
    .single (single),
    .double (double)
  );

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdChk  <= '0;
      sglErr <= 1'b0;
      dblErr <= 1'b0;
    end else if (rdS.read) begin
      if (rdS.bypass) begin
        rdData <= rdWord[DataW-1:0];
        rdChk  <= rdWord[WordW-1:DataW];
        sglErr <= 1'b0;
        dblErr <= 1'b0;
      end else begin
        rdData <= fixData;
        rdChk  <= '0;
        sglErr <= single;
        dblErr <= double;
      end
    end
  end
endmodule

// File: rtl/eccDualMem.sv
module eccDualMem
  import eccPkg::*;
#(
  parameter int AddrW = 9
) (
  input  logic             rstN,
  input  logic             wrClk,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [ChkW-1:0]  wrChk,
  input  logic [1:0]       mode,
  input  logic             rdClk,
  input  logic             rdEn,
  input  logic [AddrW-1:0] rdAddr,
  output logic [DataW-1:0] rdData,
  output logic [ChkW-1:0]  rdChk,
  output logic             sglErr,
  output logic             dblErr,
  output logic [ChkW-1:0]  encChk
);
  wrStrobeT wrS;
  rdStrobeT rdS;

  eccCtrl ctrl (
    .mode(mode),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .wrS (wrS),
    .rdS (rdS)
  );

  eccDatapath #(.AddrW(AddrW)) path (
    .rstN  (rstN),
    .wrClk (wrClk),
    .wrS   (wrS),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .wrChk (wrChk),
    .rdClk (rdClk),
    .rdS   (rdS),
    .rdAddr(rdAddr),
    .rdData(rdData),
    .rdChk (rdChk),
    .sglErr(sglErr),
    .dblErr(dblErr),
    .encChk(encChk)
  );
endmodule

// File: rtl/eccDualMemChk.sv
module eccDualMemChk
  import eccPkg::*;
(
  input logic             rstN,
  input logic             wrClk,
  input logic [DataW-1:0] wrData,
  input logic [ChkW-1:0]  encChk,
  input logic [1:0]       mode,
  input logic             rdClk,
  input logic             rdEn,
  input logic [DataW-1:0] rdData,
  input logic [ChkW-1:0]  rdChk,
  input logic             sglErr,
  input logic             dblErr
);
  assert_flags_exclusive_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    !(sglErr && dblErr));

  assert_hold_idle_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdEn |=> ($stable(rdData) && $stable(rdChk) && $stable(sglErr) && $stable(dblErr)));

  assert_bypass_quiet_R11: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && mode == 2'd1) |=> (!sglErr && !dblErr));

  assert_chk_zero_R11: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && mode != 2'd1) |=> (rdChk == '0));

  assert_even_codeword_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    (^{encChk, wrData}) == 1'b0);
endmodule

bind eccDualMem eccDualMemChk uChk (
  .rstN  (rstN),
  .wrClk (wrClk),
  .wrData(wrData),
  .encChk(encChk),
  .mode  (mode),
  .rdClk (rdClk),
  .rdEn  (rdEn),
  .rdData(rdData),
  .rdChk (rdChk),
  .sglErr(sglErr),
  .dblErr(dblErr)
);

// File: tb/tb_eccDualMem.sv
`timescale 1ns/1ps
module tb_eccDualMem;
  logic        rstN = 1'b0;
  logic        wrClk = 1'b0;
  logic        rdClk = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [7:0]  wrChk = '0;
  logic [1:0]  mode = 2'd0;
  logic        rdEn = 1'b0;
  logic [8:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic [7:0]  rdChk;
  logic        sglErr;
  logic        dblErr;
  logic [7:0]  encChk;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  logic [71:0] model [int];
  logic [63:0] expData = '0;
  logic [7:0]  expChk = '0;
  logic        expSgl = 1'b0;
  logic        expDbl = 1'b0;

  eccDualMem dut (
    .rstN(rstN), .wrClk(wrClk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrChk(wrChk), .mode(mode), .rdClk(rdClk), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .rdChk(rdChk), .sglErr(sglErr), .dblErr(dblErr), .encChk(encChk)
  );

  always #10 wrClk = ~wrClk;
  always #10 rdClk = ~rdClk;

  // Code check bits: low seven are the XOR of the positions of set data bits.
  function automatic logic [7:0] refEnc(logic [63:0] d);
    int syn = 0;
    int idx = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[idx]) syn ^= p;
        idx++;
      end
    end
    return {(^d) ^ (^syn[6:0]), syn[6:0]};
  endfunction

  task automatic refDec(input logic [71:0] w, output logic [63:0] dOut,
                        output logic s, output logic db);
    int syn = 0;
    int idx = 0;
    int k = 0;
    logic par;
    par = ^w;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) == 0) begin
        if (w[64 + k]) syn ^= p;
        k++;
      end else begin
        if (w[idx]) syn ^= p;
        idx++;
      end
    end
    dOut = w[63:0];
    idx = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (par && p == syn) dOut[idx] = ~dOut[idx];
        idx++;
      end
    end
    s  = par;
    db = !par && (syn != 0);
  endtask

  always @(posedge wrClk) begin
    if (wrEn) model[int'(wrAddr)] = {(mode == 2'd2) ? wrChk : refEnc(wrData), wrData};
  end

  always @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      expData = '0; expChk = '0; expSgl = 1'b0; expDbl = 1'b0;
    end else if (rdEn) begin
      logic [71:0] w;
      w = model[int'(rdAddr)];
      if (mode == 2'd1) begin
        expData = w[63:0]; expChk = w[71:64]; expSgl = 1'b0; expDbl = 1'b0;
      end else begin
        refDec(w, expData, expSgl, expDbl);
        expChk = '0;
      end
    end
  end

  always @(posedge rdClk) begin
    #5;
    checks++;
    if (rdData !== expData || rdChk !== expChk || sglErr !== expSgl || dblErr !== expDbl) begin
      errors++;
      $display("FAIL %s t=%0t data %h/%h chk %h/%h sgl %b/%b dbl %b/%b (actual/expected)",
               phase, $time, rdData, expData, rdChk, expChk, sglErr, expSgl, dblErr, expDbl);
    end
    checks++;
    if (encChk !== refEnc(wrData)) begin
      errors++;
      $display("FAIL R4 encChk actual %h expected %h", encChk, refEnc(wrData));
    end
  end

  task automatic wr(input int a, input logic [63:0] d, input logic [7:0] c);
    @(negedge wrClk);
    wrEn = 1'b1; wrAddr = a[8:0]; wrData = d; wrChk = c;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge rdClk);
    rdEn = 1'b1; rdAddr = a[8:0];
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge rdClk);
  endtask

  localparam logic [63:0] Base = 64'h0123_4567_89AB_CDEF;

  initial begin
    repeat (3) @(negedge rdClk);
    checks++;
    if (rdData !== '0 || rdChk !== '0 || sglErr !== 1'b0 || dblErr !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs %h %h %b %b expected zero", rdData, rdChk, sglErr, dblErr);
    end
    rstN = 1'b1;

    phase = "R5";
    wr(0, 64'h0, 8'h0);
    wr(1, {64{1'b1}}, 8'h0);
    wr(511, 64'hA5A5_5A5A_F0F0_0F0F, 8'h0);
    wr(100, Base, 8'h0);
    mode = 2'd3;
    wr(101, 64'h8000_0000_0000_0001, 8'h0);
    rd(0); rd(1); rd(511); rd(100); rd(101);
    mode = 2'd0;

    phase = "R3";
    rdAddr = 9'd1;
    idle(4);
    rd(511);
    idle(2);

    phase = "R2";
    wr(5, 64'hDEAD_BEEF_0000_1111, 8'h0);
    @(negedge wrClk);
    wrEn = 1'b0; wrAddr = 9'd5; wrData = 64'h1234; wrChk = 8'h0;
    @(negedge wrClk);
    rd(5);

    phase = "R10";
    mode = 2'd2;
    wr(10, Base, refEnc(Base));
    wr(11, 64'h55, 8'h3C);
    mode = 2'd0;
    rd(10); rd(11);

    phase = "R6";
    mode = 2'd2;
    wr(20, Base ^ 64'h1, refEnc(Base));
    wr(21, Base ^ (64'h1 << 31), refEnc(Base));
    wr(22, Base ^ (64'h1 << 63), refEnc(Base));
    mode = 2'd0;
    rd(20); rd(21); rd(22);

    phase = "R7";
    mode = 2'd2;
    for (int j = 0; j < 8; j++) wr(30 + j, Base, refEnc(Base) ^ (8'h1 << j));
    mode = 2'd0;
    for (int j = 0; j < 8; j++) rd(30 + j);

    phase = "R8";
    mode = 2'd2;
    wr(40, Base ^ 64'h3, refEnc(Base));
    wr(41, Base ^ 64'h1, refEnc(Base) ^ 8'h01);
    wr(42, Base, refEnc(Base) ^ 8'h81);
    mode = 2'd0;
    rd(40); rd(41); rd(42);

    phase = "R9";
    rd(20); rd(40); rd(20);

    phase = "R11";
    mode = 2'd1;
    rd(20); rd(41); rd(100);
    wr(60, 64'hCAFE_F00D_1357_9BDF, 8'hFF);
    rd(60);
    mode = 2'd0;
    rd(60);

    phase = "R5";
    fork
      wr(70, 64'h0F1E_2D3C_4B5A_6978, 8'h0);
      rd(100);
    join
    fork
      wr(71, 64'hFFFF_0000_FFFF_0000, 8'h0);
      rd(22);
    join
    rd(70); rd(71);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule